// File: doc/BRIEF.md
# Vector String Range Compare

This block classifies every element of a 128-bit data vector against a set of programmable ranges. A second vector holds limit values that are taken in consecutive pairs. A third vector holds one control element per limit, and the top byte of that element picks the relations (equal, below, above) under which the limit is met. A data element qualifies when both limits of at least one pair are met. Elements can be 1, 2 or 4 bytes wide. A descriptor can invert the per-element verdict and can turn on a search for the first all-zero element.

A start pulse captures all operands. The block then walks the data vector one element per clock, testing that element against every pair at once. It returns one of two result forms. The first is a mask with each qualifying element filled with ones. The second is the byte position of the first hit, capped by the first zero element. A 2-bit condition code sums up the outcome, and a one-cycle done pulse marks the end of a run. In index form the walk stops early at the first hit or at the first zero element.

Top module: `vrange_scan`

## Requirements
- R1: Element 0 is the most significant element of each vector. elem_size 0, 1 and 2 select 1, 2 and 4-byte elements. Code 3 behaves as 4-byte elements.
- R2: Limits are grouped in the pairs (0,1), (2,3) and so on. A data element qualifies only when its relations to both limits of the same pair are accepted.
- R3: For limit j, the accepting relations come from the byte at byte position j×(element bytes) of ctrl_vec: bit 7 accepts data equal to the limit, bit 6 data below it, bit 5 data above it. Bits 4..0 of that byte and all other control bytes are ignored.
- R4: Data and limits are compared as unsigned numbers at the selected element width.
- R5: desc bit 3 set complements the qualify verdict of every element. desc bits 0 and 2 have no effect.
- R6: With mask_mode=1, result has every bit of each qualifying element set to 1 and all other bits 0. This covers elements past a zero element.
- R7: With mask_mode=0, result[127:64] holds the byte position of the first qualifying element, limited to the first-zero position when zero search is on, and result[63:0] is 0. The value 16 means nothing was found.
- R8: desc bit 1 enables the zero search, which finds the first element whose bits are all zero. With it clear, zero elements are treated like any other data.
- R9: cc is 3 when neither a hit nor a zero was found, 1 when a hit but no zero was found, 2 when the first hit lies strictly before the first zero, and 0 otherwise.
- R10: busy rises on the clock edge that takes start. done pulses for one cycle, with busy low, k edges later. In mask form k is the element count. In index form k is min(first hit element, first zero element, count−1)+1. start is ignored while busy.
- R11: After reset, busy, done, cc and result are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture operands and begin a scan when idle |
| data_vec | input | 128 | Data elements to classify |
| limit_vec | input | 128 | Limit elements, used in pairs |
| ctrl_vec | input | 128 | Relation-select elements, one per limit |
| elem_size | input | 2 | Element width code |
| desc | input | 4 | Descriptor: bit 3 invert, bit 1 zero search |
| mask_mode | input | 1 | 1 = mask result, 0 = first-index result |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 128 | Mask or index result, held until the next completion |
| cc | output | 2 | Condition code |

## Verification
The bench builds the block with its default 16-byte vector. Element width is a run-time input, so the default build alone covers all three widths and the alias code. This means pair counts of 8, 4 and 2 and scan lengths of 16, 8 and 4 elements can all be driven. In particular, the bench reaches the longest 16-cycle mask scan, early stops on a hit and on a zero element, unsigned limits at 0xFFFF, and a start pulse that arrives in the middle of a long scan.

// File: rtl/vrc_pkg.sv
package vrc_pkg;

    localparam int VEC_BYTES = 16;
    localparam int VEC_BITS  = VEC_BYTES * 8;
    localparam int MAX_EB    = 4;
    localparam int EL_BITS   = MAX_EB * 8;
    localparam int IDX_W     = $clog2(VEC_BYTES + 1);
    localparam int EN_W      = $clog2(VEC_BYTES);
    localparam int PAIRS     = VEC_BYTES / 2;

    localparam int CB_EQ = 7;
    localparam int CB_LO = 6;
    localparam int CB_HI = 5;

    localparam int DESC_INV = 3;
    localparam int DESC_ZS  = 1;

    typedef logic [VEC_BITS-1:0] vec_t;
    typedef logic [EL_BITS-1:0]  elem_t;
    typedef logic [IDX_W-1:0]    bidx_t;
    typedef logic [EN_W-1:0]     eidx_t;

    localparam bidx_t NONE = bidx_t'(VEC_BYTES);

    typedef enum logic {ST_IDLE, ST_SCAN} state_e;

    typedef struct packed {
        vec_t       data;
        vec_t       lim;
        vec_t       ctl;
        logic [1:0] sh;
        logic       inv;
        logic       zs;
        logic       mmode;
    } job_t;

    // element width code to log2 of element bytes (code 3 aliases 4-byte)
    function automatic logic [1:0] size_shift(logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction

    function automatic elem_t get_elem(vec_t v, eidx_t i, logic [1:0] sh);
        elem_t e;
        e = '0;
        case (sh)
            2'd0:    e[7:0]  = v[VEC_BITS-1-8*int'(i) -: 8];
            2'd1:    e[15:0] = v[VEC_BITS-1-16*int'(i[EN_W-2:0]) -: 16];
            default: e       = v[VEC_BITS-1-32*int'(i[EN_W-3:0]) -: 32];
        endcase
        return e;
    endfunction

    function automatic logic [7:0] ctl_byte(vec_t v, eidx_t b);
        return v[VEC_BITS-1-8*int'(b) -: 8];
    endfunction

    function automatic logic rel_ok(elem_t d, elem_t l, logic [7:0] c);
        if (d < l)      return c[CB_LO];
        else if (d > l) return c[CB_HI];
        return c[CB_EQ];
    endfunction

    function automatic bidx_t min_idx(bidx_t a, bidx_t b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic [1:0] cond_code(bidx_t fm, bidx_t fz);
        if (fm == NONE && fz == NONE) return 2'd3;
        if (fz == NONE)               return 2'd1;
        if (fm < fz)                  return 2'd2;
        return 2'd0;
    endfunction

endpackage

// File: rtl/vrc_zero_find.sv
module vrc_zero_find
    import vrc_pkg::*;
(
    input  vec_t       data,
    input  logic [1:0] sh,
    input  logic       en,
    output bidx_t      first_zero
);
    always_comb begin
        first_zero = NONE;
        for (int i = VEC_BYTES - 1; i >= 0; i--) begin
            if (en && (i < (VEC_BYTES >> sh)) &&
                (get_elem(data, eidx_t'(i), sh) == '0))
                first_zero = bidx_t'(i << sh);
        end
    end
endmodule

// File: rtl/vrc_pair_eval.sv
module vrc_pair_eval
    import vrc_pkg::*;
(
    input  vec_t       lim,
    input  vec_t       ctl,
    input  elem_t      d,
    input  logic [1:0] sh,
    output logic       hit
);
    logic [PAIRS-1:0] pair_ok;

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        localparam int J0 = 2 * p;
        localparam int J1 = 2 * p + 1;
        logic  valid;
        eidx_t b0, b1;
        assign valid = (J1 < (VEC_BYTES >> sh));
        assign b0    = eidx_t'(J0 << sh);
        assign b1    = eidx_t'(J1 << sh);
        assign pair_ok[p] = valid &&
            rel_ok(d, get_elem(lim, eidx_t'(J0), sh), ctl_byte(ctl, b0)) &&
            rel_ok(d, get_elem(lim, eidx_t'(J1), sh), ctl_byte(ctl, b1));
    end

    assign hit = |pair_ok;
endmodule

// File: rtl/vrc_lane_mask.sv
module vrc_lane_mask
    import vrc_pkg::*;
(
    input  eidx_t      idx,
    input  logic [1:0] sh,
    output vec_t       lane_bits
);
    for (genvar b = 0; b < VEC_BYTES; b++) begin : g_byte
        localparam int B = b;
        logic sel;
        assign sel = (eidx_t'(B >> sh) == idx);
        assign lane_bits[VEC_BITS-1-8*B -: 8] = {8{sel}};
    end
endmodule

// File: rtl/vrange_scan.sv
module vrange_scan
    import vrc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [VEC_BITS-1:0] data_vec,
    input  logic [VEC_BITS-1:0] limit_vec,
    input  logic [VEC_BITS-1:0] ctrl_vec,
    input  logic [1:0]          elem_size,
    input  logic [3:0]          desc,
    input  logic                mask_mode,
    output logic                busy,
    output logic                done,
    output logic [VEC_BITS-1:0] result,
    output logic [1:0]          cc
);
    state_e     st;
    job_t       job;
    eidx_t      idx;
    bidx_t      fm_q;
    vec_t       acc_q;
    vec_t       res_q;
    logic [1:0] cc_q;
    logic       done_q;

    bidx_t fz;
    elem_t cur_d;
    logic  raw_hit, hit, stop_zero, last, finish;
    bidx_t n_el, cur_byte, fm_fin;
    vec_t  lane_bits, acc_nx;

    vrc_zero_find u_zero (
        .data(job.data), .sh(job.sh), .en(job.zs), .first_zero(fz)
    );

    assign cur_d = get_elem(job.data, idx, job.sh);

    vrc_pair_eval u_pairs (
        .lim(job.lim), .ctl(job.ctl), .d(cur_d), .sh(job.sh), .hit(raw_hit)
    );

    vrc_lane_mask u_lane (
        .idx(idx), .sh(job.sh), .lane_bits(lane_bits)
    );

    always_comb begin
        n_el      = bidx_t'(VEC_BYTES >> job.sh);
        cur_byte  = bidx_t'(idx) << job.sh;
        hit       = raw_hit ^ job.inv;
        stop_zero = !job.mmode && (cur_byte >= fz);
        last      = (bidx_t'(idx) == (n_el - 1'b1));
        finish    = stop_zero || (hit && !job.mmode) || last;
        if (stop_zero || !hit) fm_fin = fm_q;
        else                   fm_fin = min_idx(fm_q, cur_byte);
        acc_nx    = acc_q | ((hit && !stop_zero) ? lane_bits : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            job    <= '0;
            idx    <= '0;
            fm_q   <= NONE;
            acc_q  <= '0;
            res_q  <= '0;
            cc_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        job.data  <= data_vec;
                        job.lim   <= limit_vec;
                        job.ctl   <= ctrl_vec;
                        job.sh    <= size_shift(elem_size);
                        job.inv   <= desc[DESC_INV];
                        job.zs    <= desc[DESC_ZS];
                        job.mmode <= mask_mode;
                        idx       <= '0;
                        fm_q      <= NONE;
                        acc_q     <= '0;
                        st        <= ST_SCAN;
                    end
                end
                default: begin
                    if (finish) begin
                        st     <= ST_IDLE;
                        done_q <= 1'b1;
                        cc_q   <= cond_code(fm_fin, fz);
                        res_q  <= job.mmode ? acc_nx
                                : (vec_t'(min_idx(fm_fin, fz)) << (VEC_BITS / 2));
                    end else begin
                        idx   <= idx + 1'b1;
                        fm_q  <= fm_fin;
                        acc_q <= acc_nx;
                    end
                end
            endcase
        end
    end

    assign busy   = (st == ST_SCAN);
    assign done   = done_q;
    assign result = res_q;
    assign cc     = cc_q;
endmodule

// File: rtl/vrc_chk.sv
module vrc_chk
    import vrc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       done,
    input vec_t       result,
    input logic [1:0] cc,
    input logic       mmode,
    input vec_t       data_q
);
    logic [IDX_W:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst)       busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 1'b1;
        else           busy_cnt <= '0;
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R10
    operand_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(data_q));

    // R10
    scan_len_chk: assert property (@(posedge clk) disable iff (rst)
        busy_cnt <= (IDX_W + 1)'(VEC_BYTES));

    // R7
    index_form_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !mmode) |-> (result[VEC_BITS/2-1:0] == '0 &&
                              result[VEC_BITS-1:VEC_BITS/2] <= VEC_BYTES));

    // R9
    none_found_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !mmode && cc == 2'd3) |->
            (result[VEC_BITS-1:VEC_BITS/2] == VEC_BYTES));
endmodule

bind vrange_scan vrc_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .result(result),
    .cc(cc), .mmode(job.mmode), .data_q(job.data)
);

// File: tb/sim_vrange_scan.sv
module sim_vrange_scan;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [127:0] data_vec = '0, limit_vec = '0, ctrl_vec = '0;
    logic [1:0]   elem_size = '0;
    logic [3:0]   desc = '0;
    logic         mask_mode = 1'b0;
    logic         busy, done;
    logic [127:0] result;
    logic [1:0]   cc;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    vrange_scan u0 (
        .clk(clk), .rst(rst), .start(start), .data_vec(data_vec),
        .limit_vec(limit_vec), .ctrl_vec(ctrl_vec), .elem_size(elem_size),
        .desc(desc), .mask_mode(mask_mode), .busy(busy), .done(done),
        .result(result), .cc(cc)
    );

    task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] bget(logic [127:0] v, int i, int w);
        logic [127:0] t;
        t = v >> (128 - 8 * w * (i + 1));
        t = t & ((128'd1 << (8 * w)) - 1);
        return t[31:0];
    endfunction

    function automatic bit brel(logic [31:0] d, logic [31:0] l, logic [7:0] c);
        if (d == l) return c[7];
        if (d < l)  return c[6];
        return c[5];
    endfunction

    task automatic model(input logic [127:0] d, l, c, input logic [1:0] es,
                         input logic [3:0] ds, input logic mm,
                         output logic [127:0] eres, output int ecc, output int ecyc);
        int w, n, fz, fm, mi, zi;
        bit q;
        logic [127:0] msk;
        logic [7:0] c0, c1;
        w = (es == 2'd0) ? 1 : (es == 2'd1) ? 2 : 4;
        n = 16 / w;
        fz = 16;
        fm = 16;
        msk = '0;
        if (ds[1]) begin
            for (int i = n - 1; i >= 0; i--)
                if (bget(d, i, w) == 0) fz = i * w;
        end
        for (int i = 0; i < n; i++) begin
            q = 0;
            for (int p = 0; p < n / 2; p++) begin
                c0 = 8'((c >> (120 - 8 * (2 * p) * w)) & 128'hFF);
                c1 = 8'((c >> (120 - 8 * (2 * p + 1) * w)) & 128'hFF);
                if (brel(bget(d, i, w), bget(l, 2 * p, w), c0) &&
                    brel(bget(d, i, w), bget(l, 2 * p + 1, w), c1)) q = 1;
            end
            q = q ^ ds[3];
            if (q) begin
                msk = msk | (((128'd1 << (8 * w)) - 1) << (128 - 8 * w * (i + 1)));
                if (fm == 16) fm = i * w;
            end
        end
        if (fm == 16 && fz == 16) ecc = 3;
        else if (fz == 16)        ecc = 1;
        else if (fm < fz)         ecc = 2;
        else                      ecc = 0;
        if (mm) begin
            eres = msk;
            ecyc = n;
        end else begin
            eres = 128'((fm < fz) ? fm : fz) << 64;
            mi = (fm == 16) ? n : fm / w;
            zi = (fz == 16) ? n : fz / w;
            ecyc = ((mi < zi) ? mi : zi);
            if (ecyc > n - 1) ecyc = n - 1;
            ecyc = ecyc + 1;
        end
    endtask

    task automatic run(string tag, logic [127:0] d, l, c, logic [1:0] es,
                       logic [3:0] ds, logic mm, bit intrude);
        logic [127:0] eres;
        int ecc, ecyc;
        model(d, l, c, es, ds, mm, eres, ecc, ecyc);
        @(negedge clk);
        data_vec = d; limit_vec = l; ctrl_vec = c;
        elem_size = es; desc = ds; mask_mode = mm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1 && done === 1'b0, {tag, " R10 busy after start"},
            {126'd0, busy, done}, 128'd2);
        for (int k = 1; k <= ecyc; k++) begin
            @(negedge clk);
            chk(done === (k == ecyc), {tag, " R10 done timing"},
                128'(done), 128'(k == ecyc));
            chk(busy === (k < ecyc), {tag, " R10 busy timing"},
                128'(busy), 128'(k < ecyc));
            if (intrude && k == 1) begin
                data_vec = ~d; mask_mode = ~mm; start = 1'b1;
            end
            if (intrude && k == 2) begin
                data_vec = d; mask_mode = mm; start = 1'b0;
            end
            if (k == ecyc) begin
                chk(result === eres, {tag, " result"}, result, eres);
                chk(cc === 2'(ecc), {tag, " cc R9"}, 128'(cc), 128'(ecc));
            end
        end
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, {tag, " R10 idle after done"},
            {126'd0, busy, done}, 128'd0);
    endtask

    localparam logic [127:0] LIM_AZ = 128'h617A0000000000000000000000000000;
    localparam logic [127:0] CTL_AZ = 128'hA0C00000000000000000000000000000;
    localparam logic [127:0] TXT    = 128'h48454C4C4F5F74686572655F41424344;

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(busy === 0 && done === 0 && cc === 0 && result === '0, "R11 reset",
            {result[127:4], busy, done, cc}, 128'd0);
        rst = 1'b0;

        run("R1 R2 R7 byte index", TXT, LIM_AZ, CTL_AZ, 2'd0, 4'b0000, 1'b0, 0);
        run("R6 byte mask", TXT, LIM_AZ, CTL_AZ, 2'd0, 4'b0000, 1'b1, 0);
        run("R8 R9 zero before hit",
            128'h48454C004F5F74686572655F41424344, LIM_AZ, CTL_AZ, 2'd0, 4'b0010, 1'b0, 0);
        run("R8 R9 hit before zero",
            128'h48654C4C4F0074686572655F41424344, LIM_AZ, CTL_AZ, 2'd0, 4'b0010, 1'b0, 0);
        run("R8 zero search off",
            128'h48454C004F5F74686572655F41424344, LIM_AZ, CTL_AZ, 2'd0, 4'b0000, 1'b0, 0);
        run("R5 invert index",
            128'h68656C48656C6C6F5F41424344454647, LIM_AZ, CTL_AZ, 2'd0, 4'b1000, 1'b0, 0);
        run("R5 invert mask", TXT, LIM_AZ, CTL_AZ, 2'd0, 4'b1000, 1'b1, 0);
        run("R5 ignored desc bits", TXT, LIM_AZ, CTL_AZ, 2'd0, 4'b0101, 1'b0, 0);
        run("R3 ignored ctrl bits", TXT, LIM_AZ,
            128'hBFDF1F1F1F1F1F1F1F1F1F1F1F1F1F1F, 2'd0, 4'b0000, 1'b0, 0);
        run("R2 second pair",
            128'h41423132000000000000000000000000, 128'h00003039000000000000000000000000,
            128'h0000A0C0000000000000000000000000, 2'd0, 4'b0000, 1'b0, 0);
        run("R4 R3 halfword unsigned index",
            128'hFFFF0001800000027FFF00001234FFFE, 128'h0001FFFF000000000000000000000000,
            128'h20FF4000000000000000000000000000, 2'd1, 4'b0000, 1'b0, 0);
        run("R4 R6 halfword unsigned mask",
            128'hFFFF0001800000027FFF00001234FFFE, 128'h0001FFFF000000000000000000000000,
            128'h20FF4000000000000000000000000000, 2'd1, 4'b0010, 1'b1, 0);
        run("R1 word size",
            128'h00000001100000001000000000000000, 128'h10000000000000000000000000000000,
            128'h80000000E00000000000000000000000, 2'd2, 4'b0010, 1'b0, 0);
        run("R1 size code 3",
            128'h00000001100000001000000000000000, 128'h10000000000000000000000000000000,
            128'h80000000E00000000000000000000000, 2'd3, 4'b0000, 1'b1, 0);
        run("R9 nothing found", 128'h41414141414141414141414141414141, LIM_AZ, CTL_AZ,
            2'd0, 4'b0010, 1'b0, 0);
        run("R6 R9 mask past zero",
            128'h48004C4C4F5F74686572655F41424344, LIM_AZ, CTL_AZ, 2'd0, 4'b0010, 1'b1, 0);
        run("R10 start ignored while busy", TXT, LIM_AZ, CTL_AZ, 2'd0, 4'b0000, 1'b1, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule